// File: doc/BRIEF.md
# JPEG codec control register bank

This block is the software-facing control and status register bank of a JPEG compression and decompression engine. It holds the job setup: image dimensions, the chroma subsampling code, the table-select word, the Huffman segment length and the largest stream the output buffer can take. A small job sequencer sits beside these registers. It issues a one-cycle start to the engine when software brings the engine out of its held state with a mode selected. It then waits for the engine to finish and records either a normal completion or an overflow error, along with the produced byte count.

Software runs a job with one control word. That word carries the mode, the Huffman-reload request, the interrupt master enable and the run/hold bit. Clearing the run/hold bit holds the engine and wipes the previous job's results. Completion and overflow are latched in a write-one-to-clear status register. The single interrupt line is the OR of the status bits that are enabled in the mask, gated by the master enable. The DCT, quantization and entropy coding engine itself is outside this block.

Top module: `jpeg_ctl_regs`

## Requirements
- R1: After reset the register reads are: control 0, interrupt mask 0, status 0, image size 0x0008_0008, format 0x0100_0000, table select 0xF14, Huffman length 0x1A2, stream limit 0, produced size 0.
- R2: The register addresses are: control 0x000, interrupt mask 0x004, status 0x00C, stream size produced 0x044 (read only), image size 0x014, table select 0x03C, format 0x040, Huffman length 0x04C, stream limit 0x06C. The control register keeps only bits 29, 28, 19, 1 and 0. The interrupt mask keeps bits 11 and 1. Table select keeps bits 11:0, Huffman length keeps bits 15:0, and the stream limit keeps all 32 bits. Every kept bit reads back as written.
- R3: A write to the image size (width in bits 15:0, height in bits 31:16) takes effect only when both values lie in 8..16368. Otherwise the register keeps its previous value.
- R4: A write to the format register takes effect only when bits 31:24 hold a subsampling code from 1 to 4. The codes are 1 for 4:4:4, 2 for horizontal 4:2:2, 3 for 4:2:0 and 4 for vertical 4:2:2. The format register reads back as that code in bits 31:24 with all other bits zero.
- R5: A control write that sets bit 29 while bit 29 was 0, with a nonzero mode in bits 1:0 (1 decompress, 2 compress), makes eng_start high for exactly the next cycle and marks the block busy. No other write starts a job. eng_mode always shows control bits 1:0.
- R6: While busy, eng_done without overflow sets status bit 1, captures eng_bytes into the produced-size register and ends the job. eng_done while idle has no effect.
- R7: While busy, eng_ovf or eng_bytes greater than the stream limit ends the job. It sets status bit 11 and not bit 1, captures eng_bytes, and pulses eng_stop for one cycle. Overflow takes priority over a simultaneous eng_done.
- R8: Writing ones to the status register clears those bits. A bit being set in the same cycle stays set.
- R9: irq is high exactly when control bit 28 is 1 and some status bit is also set in the interrupt mask.
- R10: A control write with bit 29 cleared holds the engine, clears all status bits and the produced-size register, and ends any running job.
- R11: Reads of any other address return 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register byte address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| eng_start | output | 1 | One-cycle job start to the engine |
| eng_stop | output | 1 | One-cycle abort on stream overflow |
| eng_mode | output | 2 | Job mode: 1 decompress, 2 compress |
| eng_done | input | 1 | Engine finished the job |
| eng_ovf | input | 1 | Engine reports stream overflow |
| eng_bytes | input | 32 | Produced stream byte count |
| irq | output | 1 | Interrupt request |

## Verification
The hardest case to reach from the ports is a completion from the engine that lands in the same cycle as software's write-one-to-clear of that status bit. The engine stub normally finishes after a programmed delay. For this case the stub is held off with a long delay, and the bench forces a done pulse by hand in exactly the cycle that carries the clearing write. The bench also runs a job, lets the stub finish with a count above the limit, and repeats this with the overflow input raised. It re-arms with and without a hold phase and checks the late done from an abandoned job against the idle state. A behavioural model predicts every output and every register read on each clock.

// File: rtl/jcr_pkg.sv
package jcr_pkg;
  localparam int REG_AW = 12;
  localparam int REG_DW = 32;

  localparam logic [REG_AW-1:0] A_CTRL   = 12'h000;
  localparam logic [REG_AW-1:0] A_INTEN  = 12'h004;
  localparam logic [REG_AW-1:0] A_STAT   = 12'h00C;
  localparam logic [REG_AW-1:0] A_SIZE   = 12'h014;
  localparam logic [REG_AW-1:0] A_TSEL   = 12'h03C;
  localparam logic [REG_AW-1:0] A_FMT    = 12'h040;
  localparam logic [REG_AW-1:0] A_OUTLEN = 12'h044;
  localparam logic [REG_AW-1:0] A_HUFLEN = 12'h04C;
  localparam logic [REG_AW-1:0] A_LIMIT  = 12'h06C;

  localparam int CB_RUN = 29;
  localparam int CB_IEN = 28;
  localparam int CB_HUF = 19;
  localparam int SB_DONE = 1;
  localparam int SB_OVER = 11;

  localparam logic [REG_DW-1:0] CTRL_KEEP = (32'h1 << CB_RUN) | (32'h1 << CB_IEN)
                                          | (32'h1 << CB_HUF) | 32'h3;
  localparam logic [REG_DW-1:0] STAT_KEEP = (32'h1 << SB_OVER) | (32'h1 << SB_DONE);

  typedef struct packed {
    logic [15:0] h;
    logic [15:0] w;
  } dims_t;
endpackage

// File: rtl/jcr_cfg_regs.sv
module jcr_cfg_regs
  import jcr_pkg::*;
#(
  parameter int DW       = REG_DW,
  parameter int AW       = REG_AW,
  parameter int MIN_DIM  = 8,
  parameter int MAX_DIM  = 16368,
  parameter int TSEL_W   = 12,
  parameter int HUF_W    = 16,
  parameter logic [11:0] TSEL_RST = 12'hF14,
  parameter logic [15:0] HUF_RST  = 16'h01A2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [AW-1:0]     addr,
  input  logic [DW-1:0]     wdata,
  output logic [DW-1:0]     inten_o,
  output dims_t             size_o,
  output logic [7:0]        fmt_o,
  output logic [TSEL_W-1:0] tsel_o,
  output logic [HUF_W-1:0]  huf_o,
  output logic [DW-1:0]     limit_o
);
  localparam int CODE_LSB = DW - 8;
  localparam logic [7:0] CODE_MIN = 8'd1;
  localparam logic [7:0] CODE_MAX = 8'd4;

  logic [DW-1:0]     inten_q, inten_d, limit_q, limit_d;
  dims_t             size_q, size_d, size_w;
  logic [7:0]        fmt_q, fmt_d, code_w;
  logic [TSEL_W-1:0] tsel_q, tsel_d;
  logic [HUF_W-1:0]  huf_q, huf_d;
  logic              size_ok, code_ok;

  function automatic logic dim_ok(input logic [15:0] v);
    return (int'(v) >= MIN_DIM) && (int'(v) <= MAX_DIM);
  endfunction

  always_comb begin
    size_w  = dims_t'(wdata);
    code_w  = wdata[CODE_LSB +: 8];
    size_ok = dim_ok(size_w.w) && dim_ok(size_w.h);
    code_ok = (code_w >= CODE_MIN) && (code_w <= CODE_MAX);
    inten_d = inten_q;
    size_d  = size_q;
    fmt_d   = fmt_q;
    tsel_d  = tsel_q;
    huf_d   = huf_q;
    limit_d = limit_q;
    if (wr_en) begin
      unique case (addr)
        A_INTEN:  inten_d = wdata & STAT_KEEP;
        A_SIZE:   if (size_ok) size_d = size_w;
        A_FMT:    if (code_ok) fmt_d = code_w;
        A_TSEL:   tsel_d  = wdata[TSEL_W-1:0];
        A_HUFLEN: huf_d   = wdata[HUF_W-1:0];
        A_LIMIT:  limit_d = wdata;
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      inten_q <= '0;
      size_q  <= '{h: 16'(MIN_DIM), w: 16'(MIN_DIM)};
      fmt_q   <= CODE_MIN;
      tsel_q  <= TSEL_RST;
      huf_q   <= HUF_RST;
      limit_q <= '0;
    end else begin
      inten_q <= inten_d;
      size_q  <= size_d;
      fmt_q   <= fmt_d;
      tsel_q  <= tsel_d;
      huf_q   <= huf_d;
      limit_q <= limit_d;
    end
  end

  assign inten_o = inten_q;
  assign size_o  = size_q;
  assign fmt_o   = fmt_q;
  assign tsel_o  = tsel_q;
  assign huf_o   = huf_q;
  assign limit_o = limit_q;

  // R3: stored dimensions stay legal whatever is written
  p_size_legal_r3: assert property (@(posedge clk) disable iff (!rst_n)
    dim_ok(size_q.w) && dim_ok(size_q.h));

  // R4: an illegal code write leaves the format unchanged
  p_fmt_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_FMT && !code_ok) |=> $stable(fmt_q));
endmodule

// File: rtl/jcr_job_seq.sv
module jcr_job_seq
  import jcr_pkg::*;
#(
  parameter int DW = REG_DW,
  parameter int AW = REG_AW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  input  logic [DW-1:0] inten,
  input  logic [DW-1:0] limit,
  input  logic          eng_done,
  input  logic          eng_ovf,
  input  logic [DW-1:0] eng_bytes,
  output logic [DW-1:0] ctrl_o,
  output logic [DW-1:0] status_o,
  output logic [DW-1:0] outlen_o,
  output logic          eng_start,
  output logic          eng_stop,
  output logic          irq
);
  logic [DW-1:0] ctrl_q, ctrl_d, stat_q, stat_d, out_q, out_d;
  logic          busy_q, busy_d, start_q, stop_q;
  logic          ctrl_wr, stat_wr, over, fin, kill, launch;

  always_comb begin
    ctrl_wr = wr_en && (addr == A_CTRL);
    stat_wr = wr_en && (addr == A_STAT);
    over    = busy_q && (eng_ovf || (eng_bytes > limit));
    fin     = busy_q && eng_done && !over;
    kill    = ctrl_wr && !wdata[CB_RUN];
    launch  = ctrl_wr && wdata[CB_RUN] && !ctrl_q[CB_RUN]
              && (wdata[1:0] != 2'b00) && !busy_q;

    ctrl_d = ctrl_wr ? (wdata & CTRL_KEEP) : ctrl_q;

    stat_d = stat_q;
    if (stat_wr) stat_d = stat_d & ~wdata;
    if (over)    stat_d[SB_OVER] = 1'b1;
    if (fin)     stat_d[SB_DONE] = 1'b1;
    if (kill)    stat_d = '0;

    out_d = out_q;
    if (over || fin) out_d = eng_bytes;
    if (kill)        out_d = '0;

    busy_d = busy_q;
    if (over || fin) busy_d = 1'b0;
    if (launch)      busy_d = 1'b1;
    if (kill)        busy_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      stat_q  <= '0;
      out_q   <= '0;
      busy_q  <= 1'b0;
      start_q <= 1'b0;
      stop_q  <= 1'b0;
    end else begin
      ctrl_q  <= ctrl_d;
      stat_q  <= stat_d;
      out_q   <= out_d;
      busy_q  <= busy_d;
      start_q <= launch;
      stop_q  <= over;
    end
  end

  assign ctrl_o    = ctrl_q;
  assign status_o  = stat_q;
  assign outlen_o  = out_q;
  assign eng_start = start_q;
  assign eng_stop  = stop_q;
  assign irq       = ctrl_q[CB_IEN] && ((stat_q & inten) != '0);

  // R5: start lasts a single cycle
  p_start_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start |=> !eng_start);

  // R5: a start only comes with the engine released, a mode set, and a job running
  p_start_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start |-> (ctrl_q[CB_RUN] && ctrl_q[1:0] != 2'b00 && busy_q));

  // R6: clean completion records done and the byte count
  p_fin_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (fin && !kill) |=> (stat_q[SB_DONE] && out_q == $past(eng_bytes)));

  // R7: overflow records the error, aborts the engine, and ends the job
  p_over_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (over && !kill) |=> (stat_q[SB_OVER] && eng_stop && !busy_q));

  // R10: holding the engine wipes the job results
  p_hold_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    kill |=> (stat_q == '0 && out_q == '0 && !busy_q));
endmodule

// File: rtl/jpeg_ctl_regs.sv
module jpeg_ctl_regs
  import jcr_pkg::*;
#(
  parameter int DW      = REG_DW,
  parameter int AW      = REG_AW,
  parameter int MIN_DIM = 8,
  parameter int MAX_DIM = 16368,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic [AW-1:0] reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  output logic          eng_start,
  output logic          eng_stop,
  output logic [1:0]    eng_mode,
  input  logic          eng_done,
  input  logic          eng_ovf,
  input  logic [DW-1:0] eng_bytes,
  output logic          irq
);
  localparam int TSEL_W = 12;
  localparam int HUF_W  = 16;

  logic [SYNC_STAGES-1:0] rst_sync_q;
  logic                   rst_n_i;
  logic [DW-1:0]          inten, limit, ctrl, status, outlen;
  dims_t                  size;
  logic [7:0]             fmt;
  logic [TSEL_W-1:0]      tsel;
  logic [HUF_W-1:0]       huf;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_n_i = rst_sync_q[SYNC_STAGES-1];

  jcr_cfg_regs #(
    .DW(DW), .AW(AW), .MIN_DIM(MIN_DIM), .MAX_DIM(MAX_DIM),
    .TSEL_W(TSEL_W), .HUF_W(HUF_W)
  ) u_cfg (
    .clk(clk), .rst_n(rst_n_i), .wr_en(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .inten_o(inten), .size_o(size), .fmt_o(fmt), .tsel_o(tsel), .huf_o(huf),
    .limit_o(limit)
  );

  jcr_job_seq #(.DW(DW), .AW(AW)) u_seq (
    .clk(clk), .rst_n(rst_n_i), .wr_en(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .inten(inten), .limit(limit), .eng_done(eng_done), .eng_ovf(eng_ovf),
    .eng_bytes(eng_bytes), .ctrl_o(ctrl), .status_o(status), .outlen_o(outlen),
    .eng_start(eng_start), .eng_stop(eng_stop), .irq(irq)
  );

  assign eng_mode = ctrl[1:0];

  always_comb begin
    unique case (reg_addr)
      A_CTRL:   reg_rdata = ctrl;
      A_INTEN:  reg_rdata = inten;
      A_STAT:   reg_rdata = status;
      A_SIZE:   reg_rdata = size;
      A_TSEL:   reg_rdata = DW'(tsel);
      A_FMT:    reg_rdata = {fmt, {(DW-8){1'b0}}};
      A_OUTLEN: reg_rdata = outlen;
      A_HUFLEN: reg_rdata = DW'(huf);
      A_LIMIT:  reg_rdata = limit;
      default:  reg_rdata = '0;
    endcase
  end

  // R9: interrupt is never raised with the master enable off
  p_irq_gate_r9: assert property (@(posedge clk) disable iff (!rst_n_i)
    !ctrl[CB_IEN] |-> !irq);
endmodule

// File: tb/jpeg_ctl_regs_tb.sv
`timescale 1ns/100ps
module jpeg_ctl_regs_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        eng_start, eng_stop, irq;
  logic [1:0]  eng_mode;
  logic        eng_done = 1'b0, eng_ovf = 1'b0;
  logic [31:0] eng_bytes = '0;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  jpeg_ctl_regs u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .eng_start(eng_start),
    .eng_stop(eng_stop), .eng_mode(eng_mode), .eng_done(eng_done),
    .eng_ovf(eng_ovf), .eng_bytes(eng_bytes), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference model
  logic [31:0] m_ctrl, m_inten, m_stat, m_size, m_fmt, m_tsel, m_huf, m_lim, m_out;
  bit m_busy, m_start, m_stop;

  function automatic bit legal_dim(input int v);
    return v >= 8 && v <= 16368;
  endfunction

  function automatic logic [31:0] m_read(input logic [11:0] a);
    case (a)
      12'h000: return m_ctrl;
      12'h004: return m_inten;
      12'h00C: return m_stat;
      12'h014: return m_size;
      12'h03C: return m_tsel;
      12'h040: return m_fmt;
      12'h044: return m_out;
      12'h04C: return m_huf;
      12'h06C: return m_lim;
      default: return 32'h0;
    endcase
  endfunction

  function automatic string req_of(input logic [11:0] a);
    case (a)
      12'h014: return "R3";
      12'h040: return "R4";
      12'h00C: return "R8";
      12'h044: return "R6";
      12'h000, 12'h004, 12'h03C, 12'h04C, 12'h06C: return "R2";
      default: return "R11";
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ctrl = 0; m_inten = 0; m_stat = 0; m_size = 32'h0008_0008;
      m_fmt = 32'h0100_0000; m_tsel = 32'hF14; m_huf = 32'h1A2; m_lim = 0; m_out = 0;
      m_busy = 0; m_start = 0; m_stop = 0;
    end else begin
      bit ov, fi, kl, ln;
      ov = m_busy && (eng_ovf || eng_bytes > m_lim);
      fi = m_busy && eng_done && !ov;
      kl = reg_wr && reg_addr == 12'h000 && !reg_wdata[29];
      ln = reg_wr && reg_addr == 12'h000 && reg_wdata[29] && !m_ctrl[29]
           && reg_wdata[1:0] != 0 && !m_busy;
      if (reg_wr && reg_addr == 12'h00C) m_stat = m_stat & ~reg_wdata;
      if (ov) m_stat = m_stat | 32'h800;
      if (fi) m_stat = m_stat | 32'h2;
      if (ov || fi) begin m_out = eng_bytes; m_busy = 0; end
      if (ln) m_busy = 1;
      if (kl) begin m_stat = 0; m_out = 0; m_busy = 0; end
      m_start = ln;
      m_stop = ov;
      if (reg_wr) begin
        case (reg_addr)
          12'h000: m_ctrl = reg_wdata & 32'h3008_0003;
          12'h004: m_inten = reg_wdata & 32'h802;
          12'h014: if (legal_dim(reg_wdata[15:0]) && legal_dim(reg_wdata[31:16])) m_size = reg_wdata;
          12'h040: if (reg_wdata[31:24] >= 1 && reg_wdata[31:24] <= 4) m_fmt = {reg_wdata[31:24], 24'h0};
          12'h03C: m_tsel = {20'h0, reg_wdata[11:0]};
          12'h04C: m_huf = {16'h0, reg_wdata[15:0]};
          12'h06C: m_lim = reg_wdata;
          default: ;
        endcase
      end
    end
  end

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    chk("R5", {31'h0, eng_start}, {31'h0, m_start});
    chk("R7", {31'h0, eng_stop}, {31'h0, m_stop});
    chk("R5", {30'h0, eng_mode}, {30'h0, m_ctrl[1:0]});
    chk("R9", {31'h0, irq}, {31'h0, m_ctrl[28] && ((m_stat & m_inten) != 0)});
    chk(req_of(reg_addr), reg_rdata, m_read(reg_addr));
  end

  // engine stub
  int  stub_delay = 4;
  logic [31:0] stub_bytes = 32'd500;
  bit  stub_ovf = 0;
  bit  man_done = 0;
  logic [31:0] man_bytes = 0;
  bit  run = 0;
  int  cnt = 0;

  always @(negedge clk) begin
    #1;
    eng_done = man_done; eng_bytes = man_bytes; eng_ovf = 1'b0;
    if (run) begin
      if (cnt == 0) begin
        eng_done = 1'b1; eng_bytes = stub_bytes; eng_ovf = stub_ovf; run = 0;
      end else cnt--;
    end
    if (eng_start) begin run = 1; cnt = stub_delay; end
    if (eng_stop) run = 0;
  end

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); #1;
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); #1;
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, input logic [31:0] exp, input string req);
    @(negedge clk); #1;
    reg_addr = a;
    @(negedge clk);
    chk(req, reg_rdata, exp);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    idle(3); rst_n = 1'b1; idle(5);
    // R1 reset values
    rd(12'h03C, 32'hF14, "R1");
    rd(12'h04C, 32'h1A2, "R1");
    rd(12'h014, 32'h0008_0008, "R1");
    rd(12'h040, 32'h0100_0000, "R1");
    rd(12'h00C, 32'h0, "R1");
    // R2 readback and masking
    wr(12'h004, 32'hFFFF_FFFF); rd(12'h004, 32'h802, "R2");
    wr(12'h03C, 32'hABCD_E123); rd(12'h03C, 32'h123, "R2");
    wr(12'h04C, 32'h1234_01A2); rd(12'h04C, 32'h01A2, "R2");
    wr(12'h06C, 32'h0000_03E8); rd(12'h06C, 32'h3E8, "R2");
    // R3 size legality
    wr(12'h014, 32'h0010_0007); rd(12'h014, 32'h0008_0008, "R3");
    wr(12'h014, 32'h3FF1_0010); rd(12'h014, 32'h0008_0008, "R3");
    wr(12'h014, 32'h0008_3FF0); rd(12'h014, 32'h0008_3FF0, "R3");
    // R4 format codes
    wr(12'h040, 32'h00FF_FFFF); rd(12'h040, 32'h0100_0000, "R4");
    wr(12'h040, 32'h0512_3456); rd(12'h040, 32'h0100_0000, "R4");
    wr(12'h040, 32'h0300_00FF); rd(12'h040, 32'h0300_0000, "R4");
    // R5/R6 compress job, normal completion
    stub_delay = 4; stub_bytes = 500; stub_ovf = 0;
    wr(12'h000, 32'h3008_0002);
    idle(10);
    rd(12'h00C, 32'h2, "R6");
    rd(12'h044, 32'd500, "R6");
    chk("R9", {31'h0, irq}, 32'h1);
    // R8 clear
    wr(12'h00C, 32'h2); rd(12'h00C, 32'h0, "R8");
    // R5 no restart without a raise
    wr(12'h000, 32'h3008_0002); idle(10); rd(12'h00C, 32'h0, "R5");
    // R10 hold, then decompress job
    wr(12'h000, 32'h0); wr(12'h000, 32'h3000_0001);
    idle(10); rd(12'h00C, 32'h2, "R5");
    // R7 overflow by count
    wr(12'h000, 32'h0); rd(12'h044, 32'h0, "R10");
    wr(12'h06C, 32'd100); stub_bytes = 500;
    wr(12'h000, 32'h3000_0002); idle(10);
    rd(12'h00C, 32'h800, "R7");
    rd(12'h044, 32'd500, "R7");
    // R9 gate off with status pending
    wr(12'h000, 32'h2000_0002); idle(2);
    chk("R9", {31'h0, irq}, 32'h0);
    // R7 overflow by engine flag
    wr(12'h000, 32'h0); stub_bytes = 10; stub_ovf = 1;
    wr(12'h000, 32'h3000_0002); idle(10);
    rd(12'h00C, 32'h800, "R7");
    stub_ovf = 0;
    // R8 set wins over a simultaneous clear; R6 late done ignored
    wr(12'h000, 32'h0); stub_delay = 30;
    wr(12'h000, 32'h3000_0002); idle(3);
    @(negedge clk); man_done = 1; man_bytes = 20;
    #1; reg_wr = 1'b1; reg_addr = 12'h00C; reg_wdata = 32'h2;
    @(negedge clk); man_done = 0; man_bytes = 0;
    #1; reg_wr = 1'b0;
    rd(12'h00C, 32'h2, "R8");
    rd(12'h044, 32'd20, "R6");
    wr(12'h00C, 32'h2);
    idle(40);
    rd(12'h00C, 32'h0, "R6");
    // R11 unknown address
    wr(12'h080, 32'hFFFF_FFFF); rd(12'h080, 32'h0, "R11");
    rd(12'h06C, 32'd100, "R11");
    idle(3);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule